// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a running total of active time. A quarter-second tick strobe comes in from a prescaler elsewhere on the chip. An event-active level gates it. Each tick that arrives while the event is active adds one to a saturating counter, so the count is active time in quarter-second units. A clear request sets the count back to zero.

An alarm register of the same width holds a target time in the same units. Writing a nonzero value to it arms the alarm, and writing zero disarms it. There is no separate enable bit. The alarm flag is sticky. It sets when the counter steps onto a value that equals the armed alarm value, and it stays set until a clear request. The comparison is made only in a cycle in which the count steps forward. Because of this, an equal value raises the flag once, and a count that is merely sitting at the alarm value never raises it.

Top module: `eta_alarm_timer`

## Requirements
- R1: After reset is asserted, `elapsed`, `alarm_val` and `alarm_flag` all read zero.
- R2: When `qtr_tick` and `event_on` are both high in a cycle, and there is no clear request, `elapsed` increases by exactly one at the next clock edge. In all other cycles without a clear request, `elapsed` keeps its value.
- R3: When `elapsed` is all-ones, further qualified ticks leave it at all-ones. It does not wrap to zero.
- R4: A cycle with `alm_wr_en` high loads `alm_wr_data` into the alarm register, and the new value is visible on `alarm_val` after the next clock edge. A clear request does not change the alarm register.
- R5: When `elapsed` steps forward onto a value equal to a nonzero alarm value, `alarm_flag` goes high on the same clock edge at which `elapsed` takes that value. The comparison uses the alarm value held before any write in that same cycle.
- R6: While the alarm register holds zero, `alarm_flag` never rises.
- R7: Once set, `alarm_flag` stays high through later ticks, including ticks that move the count past the alarm value, until a clear request.
- R8: A clear request zeroes `elapsed` and `alarm_flag` at the next clock edge. A clear takes priority over a tick in the same cycle.
- R9: `alarm_flag` rises only on a cycle in which the count steps forward. This has two consequences. Writing an alarm value equal to the current count does not set the flag. A count held at all-ones does not set the flag either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qtr_tick | input | 1 | One-cycle quarter-second strobe |
| event_on | input | 1 | Event-active level that gates counting |
| clr_req | input | 1 | Clears the count and the alarm flag |
| alm_wr_en | input | 1 | Alarm register write strobe |
| alm_wr_data | input | CNT_W | Value written to the alarm register |
| elapsed | output | CNT_W | Current elapsed-time count |
| alarm_val | output | CNT_W | Current alarm register contents |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The counting path is driven in four ways:
- Ticks with the event high, to confirm that the count advances.
- Ticks with the event low, and the event high without ticks, to confirm that the gating is a true AND.
- A tick together with a clear, to confirm that the clear wins.
- Ticks continued past all-ones on a narrow instance, to separate saturation from wrap-around.

The alarm is tried in three ways:
- An approach from below, which sets the flag on the exact step.
- A write equal to the current count, and a count parked at saturation, both of which must not set the flag.
- A write in the same cycle as a tick, which shows that the comparison uses the old register value.

A zero alarm is stepped through several counts to confirm that it stays disarmed.

// File: rtl/eta_pkg.sv
package eta_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_STEP  = 2'd1,
    CNT_CLEAR = 2'd2,
    CNT_PEG   = 2'd3
  } cnt_act_e;

  // Clear wins over counting; a qualified tick at the top pegs.
  function automatic cnt_act_e pick_action(input logic clr,
                                           input logic qualified,
                                           input logic at_top);
    cnt_act_e act;
    if (clr)
      act = CNT_CLEAR;
    else if (qualified && at_top)
      act = CNT_PEG;
    else if (qualified)
      act = CNT_STEP;
    else
      act = CNT_HOLD;
    return act;
  endfunction

endpackage

// File: rtl/eta_counter.sv
module eta_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ev,
  input  logic         clr,
  output logic [W-1:0] count_q,
  output logic [W-1:0] count_nxt,
  output logic         stepped
);
  import eta_pkg::*;

  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  cnt_act_e act;
  logic     qualified;
  logic     at_top;

  assign qualified = tick & ev;
  assign at_top    = (count_q == TOP);
  assign act       = pick_action(clr, qualified, at_top);

  always_comb begin
    unique case (act)
      CNT_CLEAR: count_nxt = '0;
      CNT_STEP:  count_nxt = bump(count_q);
      default:   count_nxt = count_q;
    endcase
  end

  assign stepped = (act == CNT_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else
      count_q <= count_nxt;
  end

endmodule

// File: rtl/eta_alarm_reg.sv
module eta_alarm_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] alarm_q,
  output logic         armed
);

  function automatic logic nonzero(input logic [W-1:0] v);
    return |v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alarm_q <= '0;
    else if (wr_en)
      alarm_q <= wr_data;
  end

  assign armed = nonzero(alarm_q);

endmodule

// File: rtl/eta_match_flag.sv
module eta_match_flag #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stepped,
  input  logic [W-1:0] count_nxt,
  input  logic [W-1:0] alarm_q,
  input  logic         armed,
  input  logic         clr,
  output logic         hit,
  output logic         flag_q
);

  function automatic logic is_hit(input logic st, input logic arm,
                                  input logic [W-1:0] nxt,
                                  input logic [W-1:0] tgt);
    return st & arm & (nxt == tgt);
  endfunction

  assign hit = is_hit(stepped, armed, count_nxt, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (clr)
      flag_q <= 1'b0;
    else if (hit)
      flag_q <= 1'b1;
  end

endmodule

// File: rtl/eta_alarm_timer.sv
module eta_alarm_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qtr_tick,
  input  logic             event_on,
  input  logic             clr_req,
  input  logic             alm_wr_en,
  input  logic [CNT_W-1:0] alm_wr_data,
  output logic [CNT_W-1:0] elapsed,
  output logic [CNT_W-1:0] alarm_val,
  output logic             alarm_flag
);

  logic [CNT_W-1:0] count_nxt;
  logic             step_evt;
  logic             armed;
  logic             hit_evt;

  eta_counter #(.W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (qtr_tick),
    .ev        (event_on),
    .clr       (clr_req),
    .count_q   (elapsed),
    .count_nxt (count_nxt),
    .stepped   (step_evt)
  );

  eta_alarm_reg #(.W(CNT_W)) u_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (alm_wr_en),
    .wr_data (alm_wr_data),
    .alarm_q (alarm_val),
    .armed   (armed)
  );

  eta_match_flag #(.W(CNT_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .stepped   (step_evt),
    .count_nxt (count_nxt),
    .alarm_q   (alarm_val),
    .armed     (armed),
    .clr       (clr_req),
    .hit       (hit_evt),
    .flag_q    (alarm_flag)
  );

endmodule

// File: rtl/eta_alarm_checker.sv
module eta_alarm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         qtr_tick,
  input logic         event_on,
  input logic         clr_req,
  input logic         alm_wr_en,
  input logic [W-1:0] alm_wr_data,
  input logic [W-1:0] elapsed,
  input logic [W-1:0] alarm_val,
  input logic         alarm_flag,
  input logic         step_evt,
  input logic         hit_evt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && qtr_tick && event_on && elapsed != TOP) |=>
      elapsed == $past(elapsed) + ONE);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !(qtr_tick && event_on)) |=> $stable(elapsed));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && elapsed == TOP) |=> elapsed == TOP);

  assert_alarm_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alm_wr_en |=> alarm_val == $past(alm_wr_data));

  assert_alarm_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !alm_wr_en |=> $stable(alarm_val));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && qtr_tick && event_on && elapsed != TOP &&
     alarm_val != '0 && (elapsed + ONE) == alarm_val) |=> alarm_flag);

  assert_zero_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && alarm_val == '0) |=> !alarm_flag);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !clr_req) |=> alarm_flag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (elapsed == '0 && !alarm_flag));

  assert_rise_needs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !step_evt) |=> !alarm_flag);

  assert_hit_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> alarm_flag);

endmodule

bind eta_alarm_timer eta_alarm_checker #(.W(CNT_W)) u_eta_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .qtr_tick    (qtr_tick),
  .event_on    (event_on),
  .clr_req     (clr_req),
  .alm_wr_en   (alm_wr_en),
  .alm_wr_data (alm_wr_data),
  .elapsed     (elapsed),
  .alarm_val   (alarm_val),
  .alarm_flag  (alarm_flag),
  .step_evt    (step_evt),
  .hit_evt     (hit_evt)
);

// File: tb/test_eta_alarm_timer.sv
`timescale 1ns/1ps
module test_eta_alarm_timer;

  localparam int W  = 32;
  localparam int NW = 4;

  typedef struct packed {
    logic        tick;
    logic        ev;
    logic        clr;
    logic        wr;
    logic [31:0] wd;
    logic [31:0] ec;
    logic [31:0] ea;
    logic        ef;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 32'd0, 1'b0}, // R2 step
    '{1'b1, 1'b0, 1'b0, 1'b0, 32'd0, 32'd1, 32'd0, 1'b0}, // R2 event low
    '{1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 32'd0, 1'b0}, // R2 no tick
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'd3, 32'd1, 32'd3, 1'b0}, // R4 write 3
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd2, 32'd3, 1'b0}, // R5 not yet
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd3, 32'd3, 1'b1}, // R5 match
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd4, 32'd3, 1'b1}, // R7 sticky
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0, 32'd3, 1'b0}, // R8 clear
    '{1'b1, 1'b1, 1'b1, 1'b0, 32'd0, 32'd0, 32'd3, 1'b0}, // R8 clear wins
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 32'd3, 1'b0}, // R2
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd2, 32'd3, 1'b0}, // R2
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'd2, 32'd2, 32'd2, 1'b0}, // R9 write equal
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd3, 32'd2, 1'b0}, // R9 passed
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 32'd3, 32'd0, 1'b0}, // R4 write zero
    '{1'b0, 1'b0, 1'b1, 1'b0, 32'd0, 32'd0, 32'd0, 1'b0}, // R8
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd1, 32'd0, 1'b0}, // R6
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd2, 32'd0, 1'b0}, // R6
    '{1'b0, 1'b0, 1'b0, 1'b1, 32'd5, 32'd2, 32'd5, 1'b0}, // R4
    '{1'b1, 1'b1, 1'b0, 1'b1, 32'd4, 32'd3, 32'd4, 1'b0}, // R5 old value used
    '{1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 32'd4, 32'd4, 1'b1}  // R5 match 4
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, ev = 1'b0, clr = 1'b0, wr = 1'b0;
  logic [W-1:0]  wd = '0;
  logic [W-1:0]  elapsed, alarm_val;
  logic          alarm_flag;

  logic          n_tick = 1'b0, n_ev = 1'b0, n_clr = 1'b0, n_wr = 1'b0;
  logic [NW-1:0] n_wd = '0;
  logic [NW-1:0] n_elapsed, n_alarm;
  logic          n_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eta_alarm_timer #(.CNT_W(W)) i_eta_alarm_timer (
    .clk(clk), .rst_n(rst_n), .qtr_tick(tick), .event_on(ev),
    .clr_req(clr), .alm_wr_en(wr), .alm_wr_data(wd),
    .elapsed(elapsed), .alarm_val(alarm_val), .alarm_flag(alarm_flag)
  );

  eta_alarm_timer #(.CNT_W(NW)) i_eta_alarm_timer_narrow (
    .clk(clk), .rst_n(rst_n), .qtr_tick(n_tick), .event_on(n_ev),
    .clr_req(n_clr), .alm_wr_en(n_wr), .alm_wr_data(n_wd),
    .elapsed(n_elapsed), .alarm_val(n_alarm), .alarm_flag(n_flag)
  );

  task automatic check(input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Drive one cycle of inputs, then sample mid-high after the edge.
  task automatic cyc(input logic t, input logic e, input logic c,
                     input logic w, input logic [W-1:0] d);
    @(negedge clk);
    tick = t; ev = e; clr = c; wr = w; wd = d;
    @(posedge clk);
    #2;
    tick = 1'b0; ev = 1'b0; clr = 1'b0; wr = 1'b0; wd = '0;
  endtask

  task automatic ncyc(input logic t, input logic c, input logic w,
                      input logic [NW-1:0] d);
    @(negedge clk);
    n_tick = t; n_ev = t; n_clr = c; n_wr = w; n_wd = d;
    @(posedge clk);
    #2;
    n_tick = 1'b0; n_ev = 1'b0; n_clr = 1'b0; n_wr = 1'b0; n_wd = '0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count", 64'(elapsed), 64'd0);
    check("R1 alarm", 64'(alarm_val), 64'd0);
    check("R1 flag", 64'(alarm_flag), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].tick, VECS[i].ev, VECS[i].clr, VECS[i].wr, VECS[i].wd);
      check($sformatf("R2/R4-R9 vec%0d count", i), 64'(elapsed), 64'(VECS[i].ec));
      check($sformatf("R4 vec%0d alarm", i), 64'(alarm_val), 64'(VECS[i].ea));
      check($sformatf("R5-R9 vec%0d flag", i), 64'(alarm_flag), 64'(VECS[i].ef));
    end

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid count", 64'(elapsed), 64'd0);
    check("R1 mid alarm", 64'(alarm_val), 64'd0);
    check("R1 mid flag", 64'(alarm_flag), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 and R5 on the narrow instance: alarm at all-ones
    ncyc(1'b0, 1'b0, 1'b1, 4'hF);
    for (int k = 1; k < 15; k++) ncyc(1'b1, 1'b0, 1'b0, '0);
    check("R5 narrow before", 64'(n_flag), 64'd0);
    check("R2 narrow count 14", 64'(n_elapsed), 64'd14);
    ncyc(1'b1, 1'b0, 1'b0, '0);
    check("R5 narrow at top", 64'(n_flag), 64'd1);
    check("R3 narrow count top", 64'(n_elapsed), 64'd15);
    ncyc(1'b1, 1'b0, 1'b0, '0);
    ncyc(1'b1, 1'b0, 1'b0, '0);
    check("R3 narrow no wrap", 64'(n_elapsed), 64'd15);
    check("R7 narrow sticky", 64'(n_flag), 64'd1);
    ncyc(1'b0, 1'b1, 1'b0, '0);
    check("R8 narrow clear count", 64'(n_elapsed), 64'd0);
    check("R8 narrow clear flag", 64'(n_flag), 64'd0);
    check("R8 narrow alarm kept", 64'(n_alarm), 64'd15);

    // R9: saturate with the alarm disarmed, then arm at the held value
    ncyc(1'b0, 1'b0, 1'b1, 4'h0);
    for (int k = 0; k < 17; k++) ncyc(1'b1, 1'b0, 1'b0, '0);
    check("R6 narrow zero alarm", 64'(n_flag), 64'd0);
    check("R3 narrow pegged", 64'(n_elapsed), 64'd15);
    ncyc(1'b0, 1'b0, 1'b1, 4'hF);
    check("R9 narrow write equal", 64'(n_flag), 64'd0);
    ncyc(1'b1, 1'b0, 1'b0, '0);
    ncyc(1'b1, 1'b0, 1'b0, '0);
    check("R9 narrow held at top", 64'(n_flag), 64'd0);
    check("R3 narrow still top", 64'(n_elapsed), 64'd15);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule